// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command front end of a byte-wide parallel NOR flash. It watches the write cycles that a host drives on a 19-bit address bus and an 8-bit data bus. It recognises multi-cycle instruction sequences and hands each recognised instruction to a separate program/erase engine as a single-cycle request pulse. It also keeps a read-mode selector, so the read path can return array data, the identification bytes or engine status.

Every instruction opens with the same two unlock writes and then a set-up write. A byte program adds one more write, which carries the target address and data. An erase repeats the unlock pair and then ends with a confirm write, so an erase takes six writes. A write that does not match what the sequence expects sends the decoder back to idle and issues no request. The decoder also returns to idle, in array mode, at power-on reset and whenever the low-supply lockout input is high.

All inputs are synchronous to `clk`. A write is taken in the clock cycle in which `we_n` is first seen high after being low, provided `ce_n` is low in that cycle.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After `rst_n` is deasserted, `read_mode` is 0 (array) and every request output is low.
- R2: A write is taken only on a rising edge of `we_n` while `ce_n` is low. A `we_n` pulse with `ce_n` high changes neither the sequence state nor any output.
- R3: Address matching uses only `addr[14:0]`. The upper address bits are ignored. The unlock pair is AAh at 5555h followed by 55h at 2AAAh.
- R4: The writes unlock, A0h at 5555h, then (A, D) raise `req_prog` for one cycle, with `req_addr`=A and `req_data`=D.
- R5: The writes unlock, 80h at 5555h, unlock, 30h at address A raise `req_blk_erase`, with `req_addr`=A.
- R6: The writes unlock, 80h at 5555h, unlock, 10h at 5555h raise `req_chip_erase`. A 10h confirm at any other address raises nothing.
- R7: After unlock, 90h at 5555h raises `req_sig` and sets `read_mode` to 1 (signature). `sig_byte` is 20h when `addr[0]`=0 and E3h when `addr[0]`=1.
- R8: After unlock, a set-up write at 5555h raises one pulse: F0h gives `req_reset`, B0h gives `req_suspend`, 30h gives `req_resume` and B8h gives `req_pdown`. Any other set-up byte raises nothing.
- R9: `read_mode` becomes 2 (status) when a program, an erase or a resume is issued. It becomes 0 (array) on reset, suspend or power down.
- R10: Any write that does not match the expected address and data returns the decoder to idle without a request. The next correct sequence then works.
- R11: While `lockout` is high, writes are ignored, the sequence returns to idle and `read_mode` is 0.
- R12: At most one request pulse is high at a time, and each pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| lockout | input | 1 | Low-supply lockout, active high |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 19 | Write address |
| din | input | 8 | Write data |
| req_reset | output | 1 | Reset request pulse |
| req_sig | output | 1 | Read-signature request pulse |
| req_prog | output | 1 | Byte program request pulse |
| req_blk_erase | output | 1 | Block erase request pulse |
| req_chip_erase | output | 1 | Chip erase request pulse |
| req_suspend | output | 1 | Erase suspend request pulse |
| req_resume | output | 1 | Erase resume request pulse |
| req_pdown | output | 1 | Power-down request pulse |
| req_addr | output | 19 | Address that goes with a program or block erase |
| req_data | output | 8 | Data byte that goes with a program |
| read_mode | output | 2 | 0 array, 1 signature, 2 status |
| sig_byte | output | 8 | Identification byte selected by addr[0] |

## Verification
The assertions check on every cycle the properties of the pulse outputs: at most one pulse is high at a time, no pulse lasts longer than one cycle, and every pulse follows a qualified rising edge of `we_n`. They also check that a lockout clears the mode, and that program and signature pulses arrive together with their read modes. Only the bench's scenarios can show which codes and addresses each sequence accepts. The bench sweeps all 256 set-up bytes and all 256 confirm bytes, injects a malformed write at each position of a sequence, and checks that ignored writes, the upper address bits and a mid-sequence lockout leave no trace.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W      = 19,
  parameter int KEY_W       = 15,
  parameter logic [KEY_W-1:0] KEY_A = 15'h5555,
  parameter logic [KEY_W-1:0] KEY_B = 15'h2AAA,
  parameter logic [7:0] MFR_ID = 8'h20,
  parameter logic [7:0] DEV_ID = 8'hE3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lockout,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              req_reset,
  output logic              req_sig,
  output logic              req_prog,
  output logic              req_blk_erase,
  output logic              req_chip_erase,
  output logic              req_suspend,
  output logic              req_resume,
  output logic              req_pdown,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data,
  output logic [1:0]        read_mode,
  output logic [7:0]        sig_byte
);
  localparam logic [1:0] MODE_ARRAY = 2'd0;
  localparam logic [1:0] MODE_SIG   = 2'd1;
  localparam logic [1:0] MODE_STAT  = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_SETUP, S_PROG, S_ER1, S_ER2, S_CONF
  } state_t;

  state_t state, state_nx;
  logic we_q;
  logic [7:0] pulse_nx;
  logic [1:0] mode_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic [7:0] data_nx;

  wire              wr     = we_n & ~we_q & ~ce_n & ~lockout;
  wire [KEY_W-1:0]  key    = addr[KEY_W-1:0];
  wire              at_a   = key == KEY_A;
  wire              at_b   = key == KEY_B;
  wire              first  = at_a && din == 8'hAA;
  wire              second = at_b && din == 8'h55;

  assign sig_byte = addr[0] ? DEV_ID : MFR_ID;

  // pulse_nx bit order: reset, sig, prog, blk, chip, suspend, resume, pdown
  always_comb begin
    state_nx = state;
    pulse_nx = '0;
    mode_nx  = read_mode;
    addr_nx  = req_addr;
    data_nx  = req_data;
    if (wr) begin
      state_nx = S_IDLE;
      unique case (state)
        S_IDLE:  if (first)  state_nx = S_UNL1;
        S_UNL1:  if (second) state_nx = S_SETUP;
        S_SETUP: if (at_a) begin
          unique case (din)
            8'hA0: state_nx = S_PROG;
            8'h80: state_nx = S_ER1;
            8'h90: begin pulse_nx[6] = 1'b1; mode_nx = MODE_SIG;   end
            8'hF0: begin pulse_nx[7] = 1'b1; mode_nx = MODE_ARRAY; end
            8'hB0: begin pulse_nx[2] = 1'b1; mode_nx = MODE_ARRAY; end
            8'h30: begin pulse_nx[1] = 1'b1; mode_nx = MODE_STAT;  end
            8'hB8: begin pulse_nx[0] = 1'b1; mode_nx = MODE_ARRAY; end
            default: ;
          endcase
        end
        S_PROG: begin
          pulse_nx[5] = 1'b1;
          mode_nx     = MODE_STAT;
          addr_nx     = addr;
          data_nx     = din;
        end
        S_ER1: if (first)  state_nx = S_ER2;
        S_ER2: if (second) state_nx = S_CONF;
        S_CONF: begin
          if (din == 8'h30) begin
            pulse_nx[4] = 1'b1;
            mode_nx     = MODE_STAT;
            addr_nx     = addr;
          end else if (din == 8'h10 && at_a) begin
            pulse_nx[3] = 1'b1;
            mode_nx     = MODE_STAT;
          end
        end
        default: ;
      endcase
    end
    if (lockout) begin
      state_nx = S_IDLE;
      mode_nx  = MODE_ARRAY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      we_q      <= 1'b1;
      read_mode <= MODE_ARRAY;
      req_addr  <= '0;
      req_data  <= '0;
      {req_reset, req_sig, req_prog, req_blk_erase,
       req_chip_erase, req_suspend, req_resume, req_pdown} <= '0;
    end else begin
      state     <= state_nx;
      we_q      <= we_n;
      read_mode <= mode_nx;
      req_addr  <= addr_nx;
      req_data  <= data_nx;
      {req_reset, req_sig, req_prog, req_blk_erase,
       req_chip_erase, req_suspend, req_resume, req_pdown} <= pulse_nx;
    end
  end
endmodule

module flash_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lockout,
  input logic       ce_n,
  input logic       we_n,
  input logic [7:0] pulses,
  input logic [1:0] read_mode
);
  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses));
  assert_pulse_width_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulses) |=> pulses == 8'h00);
  assert_pulse_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulses) |-> $past($rose(we_n) && !ce_n && !lockout));
  assert_lockout_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |=> (pulses == 8'h00 && read_mode == 2'd0));
  assert_prog_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pulses[5] |-> read_mode == 2'd2);
  assert_sig_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulses[6] |-> read_mode == 2'd1);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk i_chk (
  .clk(clk), .rst_n(rst_n), .lockout(lockout), .ce_n(ce_n), .we_n(we_n),
  .pulses({req_reset, req_sig, req_prog, req_blk_erase,
           req_chip_erase, req_suspend, req_resume, req_pdown}),
  .read_mode(read_mode));

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, lockout = 0, ce_n = 1, we_n = 1;
  logic [18:0] addr = '0;
  logic [7:0] din = '0;
  logic req_reset, req_sig, req_prog, req_blk_erase, req_chip_erase;
  logic req_suspend, req_resume, req_pdown;
  logic [18:0] req_addr;
  logic [7:0] req_data, sig_byte;
  logic [1:0] read_mode;
  logic [7:0] got;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (.*);

  wire [7:0] pulses = {req_reset, req_sig, req_prog, req_blk_erase,
                       req_chip_erase, req_suspend, req_resume, req_pdown};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ce(input logic [18:0] a, input logic [7:0] d, input logic ce);
    @(negedge clk); ce_n = ce; addr = a; din = d; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); got = pulses; ce_n = 1;
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    wr_ce(a, d, 1'b0);
  endtask

  task automatic unlock();
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
  endtask

  function automatic logic [7:0] setup_exp(input logic [7:0] b);
    case (b)
      8'hF0: return 8'h80;
      8'h90: return 8'h40;
      8'hB0: return 8'h04;
      8'h30: return 8'h02;
      8'hB8: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mode", read_mode, 0);
    chk("R1 pulses", pulses, 0);

    // R8 / R7 / R4 / R9: sweep the set-up byte
    for (int b = 0; b < 256; b++) begin
      unlock();
      wr(19'h05555, b[7:0]);
      chk("R8 setup pulse", got, setup_exp(b[7:0]));
      if (b == 8'h90) chk("R7 sig mode", read_mode, 1);
      if (b == 8'h30) chk("R9 resume mode", read_mode, 2);
      if (b == 8'hF0 || b == 8'hB0 || b == 8'hB8) chk("R9 array mode", read_mode, 0);
      if (b == 8'hA0) begin
        chk("R4 no early pulse", got, 0);
        wr({b[2:0], 16'hBEEF}, 8'h5A);
        chk("R4 prog pulse", got, 8'h20);
        chk("R4 addr", req_addr, {b[2:0], 16'hBEEF});
        chk("R4 data", req_data, 8'h5A);
        chk("R9 prog mode", read_mode, 2);
      end
      if (b == 8'h80) begin
        unlock();
        chk("R5 no early pulse", got, 0);
        wr(19'h05555, 8'h10);
        chk("R6 chip pulse", got, 8'h08);
      end
    end

    // R5 / R6: sweep the confirm byte at a block address
    for (int c = 0; c < 256; c++) begin
      unlock(); wr(19'h05555, 8'h80); unlock();
      wr({c[2:0], 16'h1234}, c[7:0]);
      chk("R5 confirm", got, (c == 8'h30) ? 8'h10 : 8'h00);
      if (c == 8'h30) chk("R5 addr", req_addr, {c[2:0], 16'h1234});
    end

    // R10: a wrong write at each position of an erase, then a good program
    for (int p = 0; p < 5; p++) begin
      if (p == 0) wr(19'h05555, 8'hAB); else wr(19'h05555, 8'hAA);
      if (p >= 1) begin if (p == 1) wr(19'h02AAB, 8'h55); else wr(19'h02AAA, 8'h55); end
      if (p >= 2) begin if (p == 2) wr(19'h05554, 8'h80); else wr(19'h05555, 8'h80); end
      if (p >= 3) begin if (p == 3) wr(19'h05555, 8'hAE); else wr(19'h05555, 8'hAA); end
      if (p == 4) wr(19'h02AAA, 8'h54);
      chk("R10 abort no pulse", got, 0);
      wr(19'h00000, 8'h30);
      chk("R10 idle after abort", got, 0);
      unlock(); wr(19'h05555, 8'hA0); wr(19'h00123, 8'h77);
      chk("R10 recovers", got, 8'h20);
    end

    // R3: upper address bits are ignored
    wr(19'h75555, 8'hAA); wr(19'h3AAAA, 8'h55); wr(19'h45555, 8'h90);
    chk("R3 upper bits ignored", got, 8'h40);

    // R7: identification bytes
    @(negedge clk); addr = 19'h00000; #1 chk("R7 mfr", sig_byte, 8'h20);
    addr = 19'h00001; #1 chk("R7 dev", sig_byte, 8'hE3);

    // R2: writes with ce_n high are ignored
    wr_ce(19'h05555, 8'hAA, 1'b1); wr(19'h02AAA, 8'h55);
    chk("R2 no pulse", got, 0);
    unlock(); wr_ce(19'h00000, 8'h00, 1'b1); wr(19'h05555, 8'hF0);
    chk("R2 sequence kept", got, 8'h80);

    // R11: lockout mid-sequence
    unlock(); wr(19'h05555, 8'hA0); wr(19'h00010, 8'h01);
    chk("R11 pre status", read_mode, 2);
    unlock();
    @(negedge clk); lockout = 1;
    wr(19'h05555, 8'hA0);
    chk("R11 write ignored", got, 0);
    @(negedge clk); lockout = 0;
    chk("R11 mode array", read_mode, 0);
    wr(19'h05555, 8'hA0); wr(19'h00010, 8'h01);
    chk("R11 sequence cleared", got, 0);

    // R1: reset in the middle of a sequence
    unlock(); wr(19'h05555, 8'h90);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1 reset mode", read_mode, 0);
    chk("R1 reset pulses", pulses, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule